// File: doc/BRIEF.md
# Rail Fault Output Controller

This block turns the comparator results of four monitored supply rails into two active-low fault outputs, one for undervoltage (`uv_n`) and one for overvoltage (`ov_n`). Each rail gives two already-synchronised bits. One says its high-side tap is below threshold. The other says its low-side tap is above threshold. Rails 1 and 2 are always positive. A three-level polarity select decides whether rails 3 and 4 are positive or negative. On a negative rail the undervoltage and overvoltage roles of the two bits are swapped.

Each output is held asserted for a programmable number of clock cycles after its last fault clears. A strap can bypass this hold. A supply-lockout flag forces undervoltage and blocks overvoltage. A build-time variant picks one of two extra behaviours:
- an overvoltage latch, with a release input that clears it or lets it through;
- a disable input that holds both outputs released.

Top module: `rail_fault_ctrl`

## Requirements
- R1: For a positive rail (rails 1 and 2 always), `hi_below` set gives an undervoltage fault and `lo_above` set gives an overvoltage fault. Rail r uses bit r-1 of each bus.
- R2: For a negative rail the roles swap: `hi_below` set gives an overvoltage fault and `lo_above` set gives an undervoltage fault.
- R3: `pol_sel` encoding: 2'b11 (tied high) makes rails 3 and 4 positive. 2'b01 (open) makes rail 3 positive and rail 4 negative. 2'b00 (tied low) makes both negative. 2'b10 is treated as 2'b11.
- R4: `uv_n` is low when any undervoltage fault exists and `ov_n` is low when any overvoltage fault exists. Both fall 2 cycles after the fault is applied.
- R5: After all faults of one type clear, that output rises TIMEOUT_CYCLES+1 cycles after the clearing input. A new fault during the hold restarts the count from zero once the inputs are clean again.
- R6: With `timer_bypass` high, an output rises 2 cycles after its faults clear.
- R7: While `supply_lockout` is high, `uv_n` is low and `ov_n` is high, whatever the faults. When lockout ends, `uv_n` follows the same hold as after an input undervoltage.
- R8: Latch variant (VARIANT=0): an overvoltage fault seen while `ov_release` is low keeps `ov_n` low after the fault clears. A rising `ov_release` frees `ov_n` 2 cycles later if no fault remains.
- R9: Latch variant: with `ov_release` high, `ov_n` times out like `uv_n`. If `ov_release` drops during an active hold, `ov_n` stays low.
- R10: Disable variant (VARIANT=1): `out_disable` high drives both outputs high 1 cycle later. Lockout then still forces `uv_n` low 1 cycle after it rises and releases it 1 cycle after it falls, with no hold.
- R11: During reset `uv_n` is low and `ov_n` is high. After reset release with clean inputs, `uv_n` rises TIMEOUT_CYCLES cycles later.
- R12: The latch variant ignores `out_disable`, and the disable variant ignores `ov_release`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hi_below | input | NUM_RAILS | Per rail: high-side tap below threshold |
| lo_above | input | NUM_RAILS | Per rail: low-side tap above threshold |
| pol_sel | input | 2 | Three-level polarity select for rails 3 and 4 |
| supply_lockout | input | 1 | Supply too low for valid operation |
| timer_bypass | input | 1 | Skip the hold-off period |
| ov_release | input | 1 | Latch variant: low arms the OV latch, rising edge clears it |
| out_disable | input | 1 | Disable variant: holds both outputs released |
| uv_n | output | 1 | Active-low undervoltage output |
| ov_n | output | 1 | Active-low overvoltage output |

## Verification
A fault or lockout reaches an output after two registers: the input sample and the hold state. Assertion is therefore due 2 cycles after the stimulus, and a timed release is due TIMEOUT_CYCLES+1 cycles after the clearing input. Disable overrides go through only the input sample and are due after 1 cycle. A latch release is due after 2 cycles, from the release edge detector.

Each expectation is pushed with the exact cycle at which it is due. The bench checks the last cycle the output must still be asserted and the first cycle it must be released. Outputs are compared at the falling clock edge of that cycle.

// File: rtl/rfc_pkg.sv
// Shared definitions for the rail fault output controller.
// Holds the polarity-select encodings, the variant codes, the
// stage-one sample record and the rail polarity decode function.
package rfc_pkg;

    localparam logic [1:0] POL_TIED_LOW  = 2'b00;
    localparam logic [1:0] POL_FLOATING  = 2'b01;
    localparam logic [1:0] POL_RESERVED  = 2'b10;
    localparam logic [1:0] POL_TIED_HIGH = 2'b11;

    localparam int VARIANT_LATCH   = 0;
    localparam int VARIANT_DISABLE = 1;

    localparam int FIXED_POSITIVE_RAILS = 2;

    // Registered copy of the inputs that feed the hold-off logic.
    typedef struct packed {
        logic uv_flt;
        logic ov_flt;
        logic lock;
        logic bypass;
    } sample_t;

    // True when rail idx (zero-based) is set to negative polarity.
    // The rail with index 2 turns negative only when the select is tied low.
    // Rails above it also turn negative when the select floats.
    function automatic logic rail_is_negative(input int idx, input logic [1:0] sel);
        if (idx < FIXED_POSITIVE_RAILS) begin
            return 1'b0;
        end
        if (idx == FIXED_POSITIVE_RAILS) begin
            return sel == POL_TIED_LOW;
        end
        return (sel == POL_TIED_LOW) || (sel == POL_FLOATING);
    endfunction

endpackage

// File: rtl/rfc_classify.sv
// Fault classifier: maps each rail's two comparator bits to an
// undervoltage or overvoltage fault, according to the rail's polarity.
// Purely combinational. Comparator bits are assumed synchronised.
module rfc_classify #(
    parameter int NUM_RAILS = 4
) (
    input  logic [NUM_RAILS-1:0] hi_below,
    input  logic [NUM_RAILS-1:0] lo_above,
    input  logic [1:0]           pol_sel,
    output logic                 uv_fault,
    output logic                 ov_fault
);

    logic [NUM_RAILS-1:0] uv_bits;
    logic [NUM_RAILS-1:0] ov_bits;

    // One role-swap stage for each rail.
    for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
        logic neg;
        assign neg        = rfc_pkg::rail_is_negative(r, pol_sel);
        assign uv_bits[r] = neg ? lo_above[r] : hi_below[r];
        assign ov_bits[r] = neg ? hi_below[r] : lo_above[r];
    end

    // Merge the per-rail faults of each type.
    assign uv_fault = |uv_bits;
    assign ov_fault = |ov_bits;

endmodule

// File: rtl/rfc_holdoff.sv
// Hold-off timer for one fault output.
// It sets on a fault and counts clean cycles while set. It releases after
// TIMEOUT_CYCLES clean cycles, or one cycle after the fault clears when
// bypassed. A fault restarts the count. The priority order is
// fault > clear > freeze > count. Freeze holds the state set and zeroes
// the count; clear drops it at once.
module rfc_holdoff #(
    parameter int   TIMEOUT_CYCLES = 3125000,
    parameter logic RESET_ASSERTED = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault,
    input  logic clear,
    input  logic freeze,
    input  logic bypass,
    output logic asserted
);

    localparam int             CNT_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST  = CNT_W'(TIMEOUT_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    // Hold state and clean-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            asserted <= RESET_ASSERTED;
            cnt      <= '0;
        end else if (fault) begin
            asserted <= 1'b1;
            cnt      <= '0;
        end else if (clear) begin
            asserted <= 1'b0;
            cnt      <= '0;
        end else if (asserted && !freeze) begin
            if (bypass || cnt == LAST) begin
                asserted <= 1'b0;
                cnt      <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end else begin
            cnt <= '0;
        end
    end

endmodule

// File: rtl/rail_fault_ctrl.sv
// Rail fault output controller (top).
// Samples the classified faults and the control inputs once, then runs one
// hold-off timer per output. VARIANT selects either the OV latch with its
// release input, or the output disable. The input the variant does not use
// is ignored. Reset leaves UV asserted and OV released, as in lockout.
module rail_fault_ctrl #(
    parameter int NUM_RAILS      = 4,
    parameter int TIMEOUT_CYCLES = 3125000,
    parameter int VARIANT        = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] hi_below,
    input  logic [NUM_RAILS-1:0] lo_above,
    input  logic [1:0]           pol_sel,
    input  logic                 supply_lockout,
    input  logic                 timer_bypass,
    input  logic                 ov_release,
    input  logic                 out_disable,
    output logic                 uv_n,
    output logic                 ov_n
);

    import rfc_pkg::*;

    logic    uv_raw;
    logic    ov_raw;
    sample_t s_q;
    logic    uv_hold;
    logic    ov_hold;
    logic    ov_rel_pulse;
    logic    ov_freeze;

    rfc_classify #(.NUM_RAILS(NUM_RAILS)) classify_i (
        .hi_below (hi_below),
        .lo_above (lo_above),
        .pol_sel  (pol_sel),
        .uv_fault (uv_raw),
        .ov_fault (ov_raw)
    );

    // Stage one: register the classified faults and the shared controls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q.uv_flt <= uv_raw;
            s_q.ov_flt <= ov_raw;
            s_q.lock   <= supply_lockout;
            s_q.bypass <= timer_bypass;
        end
    end

    // UV hold: lockout counts as an undervoltage fault.
    rfc_holdoff #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .RESET_ASSERTED(1'b1)) uv_hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (s_q.uv_flt | s_q.lock),
        .clear    (1'b0),
        .freeze   (1'b0),
        .bypass   (s_q.bypass),
        .asserted (uv_hold)
    );

    // OV hold: lockout blocks and clears it.
    rfc_holdoff #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES), .RESET_ASSERTED(1'b0)) ov_hold_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault    (s_q.ov_flt & ~s_q.lock),
        .clear    (s_q.lock | ov_rel_pulse),
        .freeze   (ov_freeze),
        .bypass   (s_q.bypass),
        .asserted (ov_hold)
    );

    if (VARIANT == VARIANT_LATCH) begin : g_latch
        logic rel_q;
        logic rel_qq;
        logic unused_disable;

        // Sample the release input and keep one cycle of history to find edges.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rel_q  <= 1'b1;
                rel_qq <= 1'b1;
            end else begin
                rel_q  <= ov_release;
                rel_qq <= rel_q;
            end
        end

        assign ov_rel_pulse   = rel_q & ~rel_qq;
        assign ov_freeze      = ~rel_q;
        assign unused_disable = out_disable;
        assign uv_n           = ~uv_hold;
        assign ov_n           = ~ov_hold;
    end else begin : g_disable
        logic dis_q;
        logic unused_release;

        // Sample the disable input.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                dis_q <= 1'b0;
            end else begin
                dis_q <= out_disable;
            end
        end

        assign ov_rel_pulse   = 1'b0;
        assign ov_freeze      = 1'b0;
        assign unused_release = ov_release;
        assign uv_n           = dis_q ? ~s_q.lock : ~uv_hold;
        assign ov_n           = dis_q ? 1'b1 : ~ov_hold;
    end

endmodule

// File: rtl/rail_fault_ctrl_chk.sv
// Property checker for rail_fault_ctrl, attached by bind below.
// Watches ports only. It waits until two clean cycles have passed since
// reset, so that no two-deep look-back reaches into reset.
module rail_fault_ctrl_chk #(
    parameter int VARIANT = 0
) (
    input logic clk,
    input logic rst_n,
    input logic rail0_hi,
    input logic supply_lockout,
    input logic out_disable,
    input logic ov_release,
    input logic uv_n,
    input logic ov_n
);

    localparam int VAR_LATCH   = 0;
    localparam int VAR_DISABLE = 1;

    logic [1:0] age;
    logic       aged;

    // Count the cycles since reset, saturating at 3.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= '0;
        end else if (age != 2'd3) begin
            age <= age + 2'd1;
        end
    end

    assign aged = age >= 2'd2;

    assert_lockout_uv_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && $past(supply_lockout) && $past(supply_lockout, 2)) |-> !uv_n);

    assert_lockout_ov_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && $past(supply_lockout) && $past(supply_lockout, 2)) |-> ov_n);

    assert_rail1_uv_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (aged && $past(rail0_hi, 2) && (VARIANT == VAR_LATCH || !$past(out_disable))) |-> !uv_n);

    assert_disable_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT == VAR_DISABLE && aged && $past(out_disable) && !$past(supply_lockout)) |-> (uv_n && ov_n));

    assert_disable_lockout_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT == VAR_DISABLE && aged && $past(out_disable) && $past(supply_lockout)) |-> (!uv_n && ov_n));

    assert_latch_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (VARIANT == VAR_LATCH && aged && !$past(ov_n) && !$past(ov_release, 2)
         && !$past(supply_lockout, 2)) |-> !ov_n);

endmodule

bind rail_fault_ctrl rail_fault_ctrl_chk #(.VARIANT(VARIANT)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .rail0_hi       (hi_below[0]),
    .supply_lockout (supply_lockout),
    .out_disable    (out_disable),
    .ov_release     (ov_release),
    .uv_n           (uv_n),
    .ov_n           (ov_n)
);

// File: tb/rail_fault_ctrl_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes cycle-stamped expectations and the
// monitor compares them at the falling edge of their due cycle.
// dut_i is the latch variant and dut_dis_i is the disable variant.
module rail_fault_ctrl_tb_top;

    localparam int T = 10;

    typedef struct {
        int    due;
        int    which;   // 0 latch, 1 disable, 2 both
        logic  uv;
        logic  ov;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hi_below = '0;
    logic [3:0] lo_above = '0;
    logic [1:0] pol_sel = 2'b11;
    logic       supply_lockout = 1'b0;
    logic       timer_bypass = 1'b0;
    logic       ov_release = 1'b1;
    logic       out_disable = 1'b0;
    logic       uv_a, ov_a, uv_b, ov_b;

    int   cyc = 0;
    int   checks = 0;
    int   errors = 0;
    exp_t q[$];

    always #2 clk = ~clk;

    always @(posedge clk) cyc = cyc + 1;

    rail_fault_ctrl #(.NUM_RAILS(4), .TIMEOUT_CYCLES(T), .VARIANT(0)) dut_i (
        .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
        .pol_sel(pol_sel), .supply_lockout(supply_lockout), .timer_bypass(timer_bypass),
        .ov_release(ov_release), .out_disable(out_disable), .uv_n(uv_a), .ov_n(ov_a));

    rail_fault_ctrl #(.NUM_RAILS(4), .TIMEOUT_CYCLES(T), .VARIANT(1)) dut_dis_i (
        .clk(clk), .rst_n(rst_n), .hi_below(hi_below), .lo_above(lo_above),
        .pol_sel(pol_sel), .supply_lockout(supply_lockout), .timer_bypass(timer_bypass),
        .ov_release(ov_release), .out_disable(out_disable), .uv_n(uv_b), .ov_n(ov_b));

    task automatic compare_one(string tag, string who, logic au, logic ao, logic eu, logic eo);
        checks++;
        if (au !== eu || ao !== eo) begin
            errors++;
            $display("FAIL %s %s cycle %0d: uv_n,ov_n actual=%b%b expected=%b%b",
                     tag, who, cyc, au, ao, eu, eo);
        end
    endtask

    // Monitor: pop every expectation due at this cycle and compare it.
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].due <= cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.which != 1) compare_one(e.tag, "latch", uv_a, ov_a, e.uv, e.ov);
            if (e.which != 0) compare_one(e.tag, "disable", uv_b, ov_b, e.uv, e.ov);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(int d, int which, logic uv, logic ov, string tag);
        exp_t e;
        e.due = cyc + d; e.which = which; e.uv = uv; e.ov = ov; e.tag = tag;
        q.push_back(e);
    endtask

    // Apply one fault pattern, check the assertion, then check the timed release.
    task automatic fault_cycle(logic [1:0] pol, logic [3:0] hi, logic [3:0] lo,
                               logic eu, logic eo, string tag);
        pol_sel = pol; hi_below = hi; lo_above = lo;
        expect_out(2, 2, eu, eo, tag);
        tick(2);
        hi_below = '0; lo_above = '0;
        expect_out(T, 2, eu, eo, tag);
        expect_out(T + 1, 2, 1'b1, 1'b1, tag);
        tick(T + 1);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements: actual=no finish expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(3);
        // R11: reset state
        expect_out(1, 2, 1'b0, 1'b1, "R11");
        tick(1);
        rst_n = 1'b1;
        expect_out(T - 1, 2, 1'b0, 1'b1, "R11");
        expect_out(T, 2, 1'b1, 1'b1, "R11");
        tick(T);

        // R1: positive rails 1 and 2
        fault_cycle(2'b11, 4'b0001, 4'b0000, 1'b0, 1'b1, "R1");
        fault_cycle(2'b11, 4'b0000, 4'b0010, 1'b1, 1'b0, "R1");
        // R3: tied high, both selectable rails positive
        fault_cycle(2'b11, 4'b0100, 4'b0000, 1'b0, 1'b1, "R3");
        fault_cycle(2'b11, 4'b0000, 4'b1000, 1'b1, 1'b0, "R3");
        // R3/R2: floating, rail 3 positive, rail 4 negative
        fault_cycle(2'b01, 4'b0100, 4'b0000, 1'b0, 1'b1, "R3");
        fault_cycle(2'b01, 4'b1000, 4'b0000, 1'b1, 1'b0, "R2");
        fault_cycle(2'b01, 4'b0000, 4'b1000, 1'b0, 1'b1, "R2");
        // R2: tied low, both negative
        fault_cycle(2'b00, 4'b0100, 4'b0000, 1'b1, 1'b0, "R2");
        fault_cycle(2'b00, 4'b0000, 4'b0100, 1'b0, 1'b1, "R2");
        // R3: reserved code acts as tied high
        fault_cycle(2'b10, 4'b1000, 4'b0000, 1'b0, 1'b1, "R3");
        // R4: both types at once
        fault_cycle(2'b11, 4'b0001, 4'b0010, 1'b0, 1'b0, "R4");
        // R9: OV timeout with release high
        fault_cycle(2'b11, 4'b0000, 4'b0001, 1'b1, 1'b0, "R9");

        // R5: refault during the hold restarts it
        hi_below = 4'b0001;
        expect_out(2, 2, 1'b0, 1'b1, "R5");
        tick(2);
        hi_below = '0;
        tick(5);
        hi_below = 4'b0001;
        tick(1);
        hi_below = '0;
        expect_out(T - 5, 2, 1'b0, 1'b1, "R5");
        expect_out(T, 2, 1'b0, 1'b1, "R5");
        expect_out(T + 1, 2, 1'b1, 1'b1, "R5");
        tick(T + 1);

        // R6: bypass
        timer_bypass = 1'b1;
        tick(2);
        hi_below = 4'b0001;
        expect_out(2, 2, 1'b0, 1'b1, "R6");
        tick(2);
        hi_below = '0;
        expect_out(1, 2, 1'b0, 1'b1, "R6");
        expect_out(2, 2, 1'b1, 1'b1, "R6");
        tick(2);
        timer_bypass = 1'b0;
        tick(2);

        // R7: lockout forces UV and blocks OV
        supply_lockout = 1'b1; lo_above = 4'b0001;
        expect_out(2, 2, 1'b0, 1'b1, "R7");
        expect_out(4, 2, 1'b0, 1'b1, "R7");
        tick(4);
        supply_lockout = 1'b0; lo_above = '0;
        expect_out(T, 2, 1'b0, 1'b1, "R7");
        expect_out(T + 1, 2, 1'b1, 1'b1, "R7");
        tick(T + 1);

        // R8: OV latch held until release rises
        ov_release = 1'b0;
        tick(2);
        lo_above = 4'b0001;
        expect_out(2, 2, 1'b1, 1'b0, "R8");
        tick(2);
        lo_above = '0;
        expect_out(T, 1, 1'b1, 1'b0, "R12");
        expect_out(T + 1, 1, 1'b1, 1'b1, "R12");
        expect_out(T + 3, 0, 1'b1, 1'b0, "R8");
        tick(T + 3);
        ov_release = 1'b1;
        expect_out(1, 0, 1'b1, 1'b0, "R8");
        expect_out(2, 0, 1'b1, 1'b1, "R8");
        tick(2);

        // R9: release dropped during an active hold latches OV
        lo_above = 4'b0001;
        expect_out(2, 2, 1'b1, 1'b0, "R9");
        tick(2);
        lo_above = '0;
        tick(3);
        ov_release = 1'b0;
        expect_out(T - 3, 1, 1'b1, 1'b0, "R12");
        expect_out(T - 2, 1, 1'b1, 1'b1, "R12");
        expect_out(T + 2, 0, 1'b1, 1'b0, "R9");
        tick(T + 2);
        ov_release = 1'b1;
        expect_out(2, 0, 1'b1, 1'b1, "R9");
        tick(2);

        // R10: disable overrides faults; lockout still drives UV with no hold
        hi_below = 4'b0001; out_disable = 1'b1;
        expect_out(1, 1, 1'b1, 1'b1, "R10");
        expect_out(2, 0, 1'b0, 1'b1, "R12");
        tick(2);
        supply_lockout = 1'b1;
        expect_out(1, 1, 1'b0, 1'b1, "R10");
        expect_out(2, 0, 1'b0, 1'b1, "R7");
        tick(3);
        supply_lockout = 1'b0;
        expect_out(1, 1, 1'b1, 1'b1, "R10");
        tick(2);
        hi_below = '0; out_disable = 1'b0;
        expect_out(1, 1, 1'b0, 1'b1, "R10");
        expect_out(T, 2, 1'b0, 1'b1, "R5");
        expect_out(T + 1, 2, 1'b1, 1'b1, "R5");
        tick(T + 3);

        if (q.size() != 0) begin
            errors++;
            $display("FAIL scoreboard all requirements: actual=%0d pending expected=0", q.size());
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule